// File: doc/BRIEF.md
# Wiper and Data Register Bank

This block holds the digital state behind a bank of potentiometer channels. Each channel keeps a volatile wiper value that drives its tap switch, and a small set of data slots that stand in for non-volatile storage. A command sequencer drives requests into the bank. A request can set or read a wiper, set or read a data slot, or copy a value between a wiper and a slot on one channel or on every channel at once. It can also move a wiper by one step. Every wiper value is decoded into a one-hot tap select vector.

Writes to the slots are held in flops. They still behave like a slow storage array. Any request that changes a slot starts a write window of a parameter-set number of clock cycles, and a busy flag is high for that window. Further slot-changing requests are dropped until the window closes.

There are two synchronous resets. `por_n` is the power-on reset and clears the whole bank to a parameter value. `rst_n` resets only the volatile part: each wiper is reloaded from its slot 0, and the slots keep their contents.

Top module: `wiper_bank`

## Requirements
- R1: While `por_n` is low, every data slot and every wiper is set to `DR_INIT` on the next clock edge, and `busy` is low.
- R2: While `rst_n` is low (with `por_n` high), each wiper loads its own slot 0 on every clock edge. Requests are ignored during this time, and the write window keeps counting.
- R3: `tap_sel[c*64 + k]` is high exactly when wiper `c` equals `k`. Exactly one of the 64 bits is set per channel, so 0x00 selects bit 0 (the low end) and 0x3F selects bit 63 (the high end).
- R4: `req_op` 1 writes `req_data` into wiper `req_ch`. Op 2 reads wiper `req_ch`, and op 4 reads slot `req_reg` of channel `req_ch`. Read data appears on `rd_data`, with `rd_valid` high for one cycle, on the cycle after the request edge.
- R5: Op 5 copies slot `req_reg` of channel `req_ch` into that channel's wiper. Op 6 copies wiper `req_ch` into slot `req_reg` of the same channel.
- R6: An accepted slot change (op 3 writes `req_data` to a slot, or op 6, or op 8) raises `busy` from the next cycle. `busy` stays high for exactly `WRITE_CYCLES` cycles.
- R7: Op 9 moves wiper `req_ch` up by one when `req_up` is 1, and down by one when it is 0. The value saturates at 0x3F going up and at 0x00 going down.
- R8: While `busy` is high, ops 3, 6 and 8 leave every slot unchanged. Wiper writes, steps, copies into wipers and reads still take effect.
- R9: Op 7 loads every wiper from its own slot `req_reg`. Op 8 stores every wiper into its own slot `req_reg`, so the slot index is the same on every channel.
- R10: Slot contents survive a pulse of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low, clears the whole bank |
| rst_n | input | 1 | Synchronous wiper reset, active low, recalls slot 0 |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 4 | Operation code (see requirements) |
| req_ch | input | 2 | Channel index |
| req_reg | input | 2 | Data slot index |
| req_data | input | 6 | Write data |
| req_up | input | 1 | Step direction: 1 up, 0 down |
| rd_data | output | 6 | Read result |
| rd_valid | output | 1 | Read result valid, one-cycle pulse |
| busy | output | 1 | Write window in progress |
| tap_sel | output | 256 | One-hot tap select, 64 bits per channel |

## Verification
The bench builds the bank with `WRITE_CYCLES` = 20, so a complete write window fits in a short run. It can then observe both the start and the end of `busy`, and drop slot writes inside the window. `DR_INIT` is set to 21, which is neither zero nor a saturation point. With that value, recall from slot 0 cannot be confused with a plain clear, and steps from the initial value move freely. Channel and slot counts stay at their defaults, so every channel and every slot index is reachable by the global copies and by the warm reset.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP        = 4'd0,
        OP_SET_WIPER  = 4'd1,
        OP_GET_WIPER  = 4'd2,
        OP_SET_SLOT   = 4'd3,
        OP_GET_SLOT   = 4'd4,
        OP_LOAD       = 4'd5,
        OP_SAVE       = 4'd6,
        OP_LOAD_ALL   = 4'd7,
        OP_SAVE_ALL   = 4'd8,
        OP_STEP       = 4'd9
    } op_e;

endpackage

// File: rtl/nv_write_timer.sv
module nv_write_timer #(
    parameter int unsigned CYCLES = 1000000
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!por_n) begin
            cnt_d = '0;
        end else if (start) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R6: a store raises the flag on the next cycle
    assert_busy_after_store_R6: assert property (@(posedge clk) disable iff (!por_n)
        start |=> busy);

    // R6: the flag holds until the last counted cycle
    assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!por_n)
        (busy && cnt_q != CNT_W'(1)) |=> busy);

    // R6: the flag drops after the last counted cycle
    assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!por_n)
        (cnt_q == CNT_W'(1) && !start) |=> !busy);

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
    parameter int NUM_CH = 4,
    parameter int WIDTH  = 6
) (
    input  logic [NUM_CH*WIDTH-1:0]        wiper_flat,
    output logic [NUM_CH*(1<<WIDTH)-1:0]   tap_sel
);
    localparam int TAPS = 1 << WIDTH;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [TAPS-1:0] onehot;
        always_comb begin
            onehot = '0;
            onehot[wiper_flat[ch*WIDTH +: WIDTH]] = 1'b1;
        end
        assign tap_sel[ch*TAPS +: TAPS] = onehot;
    end

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
    parameter int          NUM_CH       = 4,
    parameter int          NUM_REG      = 4,
    parameter int          WIDTH        = 6,
    parameter int unsigned WRITE_CYCLES = 1000000,
    parameter int unsigned DR_INIT      = 32
) (
    input  logic                                clk,
    input  logic                                por_n,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic [wiper_bank_pkg::OP_W-1:0]     req_op,
    input  logic [$clog2(NUM_CH)-1:0]           req_ch,
    input  logic [$clog2(NUM_REG)-1:0]          req_reg,
    input  logic [WIDTH-1:0]                    req_data,
    input  logic                                req_up,
    output logic [WIDTH-1:0]                    rd_data,
    output logic                                rd_valid,
    output logic                                busy,
    output logic [NUM_CH*(1<<WIDTH)-1:0]        tap_sel
);
    import wiper_bank_pkg::*;

    localparam int TAPS = 1 << WIDTH;
    localparam logic [WIDTH-1:0] WMAX = WIDTH'(TAPS - 1);
    localparam logic [WIDTH-1:0] INIT_V = WIDTH'(DR_INIT);

    typedef logic [WIDTH-1:0] val_t;

    typedef struct packed {
        val_t [NUM_CH-1:0]              wiper;
        val_t [NUM_CH-1:0][NUM_REG-1:0] slot;
        val_t                           rd_data;
        logic                           rd_valid;
    } state_t;

    state_t s_d, s_q;
    logic   store_go;
    op_e    op;

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        store_go     = 1'b0;
        op           = op_e'(req_op);

        if (!por_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                s_d.wiper[c] = INIT_V;
                for (int r = 0; r < NUM_REG; r++) begin
                    s_d.slot[c][r] = INIT_V;
                end
            end
            s_d.rd_data = '0;
        end else if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                s_d.wiper[c] = s_q.slot[c][0];
            end
        end else if (req_valid) begin
            unique case (op)
                OP_SET_WIPER: s_d.wiper[req_ch] = req_data;
                OP_GET_WIPER: begin
                    s_d.rd_data  = s_q.wiper[req_ch];
                    s_d.rd_valid = 1'b1;
                end
                OP_GET_SLOT: begin
                    s_d.rd_data  = s_q.slot[req_ch][req_reg];
                    s_d.rd_valid = 1'b1;
                end
                OP_SET_SLOT: begin
                    if (!busy) begin
                        s_d.slot[req_ch][req_reg] = req_data;
                        store_go = 1'b1;
                    end
                end
                OP_LOAD: s_d.wiper[req_ch] = s_q.slot[req_ch][req_reg];
                OP_SAVE: begin
                    if (!busy) begin
                        s_d.slot[req_ch][req_reg] = s_q.wiper[req_ch];
                        store_go = 1'b1;
                    end
                end
                OP_LOAD_ALL: begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        s_d.wiper[c] = s_q.slot[c][req_reg];
                    end
                end
                OP_SAVE_ALL: begin
                    if (!busy) begin
                        for (int c = 0; c < NUM_CH; c++) begin
                            s_d.slot[c][req_reg] = s_q.wiper[c];
                        end
                        store_go = 1'b1;
                    end
                end
                OP_STEP: begin
                    if (req_up) begin
                        if (s_q.wiper[req_ch] != WMAX) begin
                            s_d.wiper[req_ch] = s_q.wiper[req_ch] + 1'b1;
                        end
                    end else begin
                        if (s_q.wiper[req_ch] != '0) begin
                            s_d.wiper[req_ch] = s_q.wiper[req_ch] - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    nv_write_timer #(
        .CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .por_n (por_n),
        .start (store_go),
        .busy  (busy)
    );

    logic [NUM_CH*WIDTH-1:0]         wiper_flat;
    logic [NUM_CH*WIDTH-1:0]         slot0_flat;
    logic [NUM_CH*NUM_REG*WIDTH-1:0] slot_flat;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wiper_flat[c*WIDTH +: WIDTH] = s_q.wiper[c];
            slot0_flat[c*WIDTH +: WIDTH] = s_q.slot[c][0];
        end
    end
    assign slot_flat = s_q.slot;

    wiper_tap_decode #(
        .NUM_CH (NUM_CH),
        .WIDTH  (WIDTH)
    ) u_decode (
        .wiper_flat (wiper_flat),
        .tap_sel    (tap_sel)
    );

    assign rd_data  = s_q.rd_data;
    assign rd_valid = s_q.rd_valid;

    // R2: a warm reset cycle reloads every wiper from its slot 0
    assert_recall_R2: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (wiper_flat == $past(slot0_flat)));

    // R8 / R10: slots never change while a write window is open
    assert_slots_frozen_R8: assert property (@(posedge clk) disable iff (!por_n)
        busy |=> $stable(slot_flat));

    // R7: stepping up at the top or down at the bottom leaves the wipers alone
    assert_step_saturate_R7: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && req_valid && op == OP_STEP &&
         ((req_up && s_q.wiper[req_ch] == WMAX) || (!req_up && s_q.wiper[req_ch] == '0)))
        |=> $stable(wiper_flat));

    // R4: every read request yields a valid pulse next cycle
    assert_read_valid_R4: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && req_valid && (op == OP_GET_WIPER || op == OP_GET_SLOT)) |=> rd_valid);

    // R3: each channel drives exactly one tap
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        assert_tap_onehot_R3: assert property (@(posedge clk) disable iff (!por_n)
            $onehot(tap_sel[ch*TAPS +: TAPS]));
    end

endmodule

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb;
    localparam int NC   = 4;
    localparam int NR   = 4;
    localparam int W    = 6;
    localparam int WC   = 20;
    localparam int INIT = 21;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           por_n, rst_n, req_valid, req_up;
    logic [3:0]     req_op;
    logic [1:0]     req_ch, req_reg;
    logic [W-1:0]   req_data;
    logic [W-1:0]   rd_data;
    logic           rd_valid, busy;
    logic [NC*64-1:0] tap_sel;

    wiper_bank #(
        .NUM_CH(NC), .NUM_REG(NR), .WIDTH(W), .WRITE_CYCLES(WC), .DR_INIT(INIT)
    ) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
        .req_op(req_op), .req_ch(req_ch), .req_reg(req_reg), .req_data(req_data),
        .req_up(req_up), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .tap_sel(tap_sel)
    );

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] m_w  [NC];
    logic [W-1:0] m_dr [NC][NR];
    int           m_cnt = 0;
    logic         m_start = 1'b0;

    typedef struct {
        logic [W-1:0] v;
        string        tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of the write window (R6)
    always @(posedge clk) begin
        if (!por_n)          m_cnt <= 0;
        else if (m_start)    m_cnt <= WC;
        else if (m_cnt != 0) m_cnt <= m_cnt - 1;
    end

    // Monitor: read scoreboard and busy flag
    always @(negedge clk) begin
        if (por_n && rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected read", 64'(rd_data), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rd_data == e.v, e.tag, 64'(rd_data), 64'(e.v));
                end
            end
            chk(busy == (m_cnt != 0), "R6 busy window", 64'(busy), 64'(m_cnt != 0));
        end
    end

    task automatic issue(input int op, input int ch, input int rg, input int d, input bit up, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 4'(op);
        req_ch    = 2'(ch);
        req_reg   = 2'(rg);
        req_data  = W'(d);
        req_up    = up;
        case (op)
            1: m_w[ch] = W'(d);
            2: begin e.v = m_w[ch]; e.tag = tag; exp_q.push_back(e); end
            3: if (m_cnt == 0) begin m_dr[ch][rg] = W'(d); m_start = 1'b1; end
            4: begin e.v = m_dr[ch][rg]; e.tag = tag; exp_q.push_back(e); end
            5: m_w[ch] = m_dr[ch][rg];
            6: if (m_cnt == 0) begin m_dr[ch][rg] = m_w[ch]; m_start = 1'b1; end
            7: for (int c = 0; c < NC; c++) m_w[c] = m_dr[c][rg];
            8: if (m_cnt == 0) begin
                   for (int c = 0; c < NC; c++) m_dr[c][rg] = m_w[c];
                   m_start = 1'b1;
               end
            9: if (up) begin
                   if (m_w[ch] != 6'h3F) m_w[ch] = m_w[ch] + 1'b1;
               end else begin
                   if (m_w[ch] != 6'h00) m_w[ch] = m_w[ch] - 1'b1;
               end
            default: ;
        endcase
        @(negedge clk);
        req_valid = 1'b0;
        m_start   = 1'b0;
    endtask

    task automatic check_taps(input string tag);
        for (int c = 0; c < NC; c++) begin
            chk(tap_sel[c*64 +: 64] == (64'd1 << m_w[c]), tag,
                tap_sel[c*64 +: 64], 64'd1 << m_w[c]);
        end
    endtask

    task automatic wait_idle();
        while (m_cnt != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0; req_valid = 1'b0;
        req_op = '0; req_ch = '0; req_reg = '0; req_data = '0; req_up = 1'b0;
        for (int c = 0; c < NC; c++) begin
            m_w[c] = W'(INIT);
            for (int r = 0; r < NR; r++) m_dr[c][r] = W'(INIT);
        end
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: cleared state
        check_taps("R1 reset wiper taps");
        chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 0);
        issue(4, 3, 2, 0, 0, "R1 slot reset value");

        // R4 / R3: direct writes, reads, tap ends
        issue(1, 1, 0, 6'h3F, 0, "R4");
        issue(2, 1, 0, 0, 0, "R4 read wiper high end");
        issue(1, 2, 0, 6'h00, 0, "R4");
        check_taps("R3 taps at both ends");
        chk(tap_sel[1*64 + 63] == 1'b1, "R3 high end is bit 63", 64'(tap_sel[127]), 1);
        chk(tap_sel[2*64 + 0] == 1'b1, "R3 low end is bit 0", 64'(tap_sel[128]), 1);

        // R7: stepping and saturation
        issue(9, 1, 0, 0, 1, "R7");
        issue(9, 2, 0, 0, 0, "R7");
        issue(9, 0, 0, 0, 1, "R7");
        issue(9, 0, 0, 0, 0, "R7");
        issue(9, 0, 0, 0, 0, "R7");
        issue(2, 1, 0, 0, 0, "R7 up saturates at 0x3F");
        issue(2, 2, 0, 0, 0, "R7 down saturates at 0x00");
        issue(2, 0, 0, 0, 0, "R7 net step");
        check_taps("R7 taps after steps");

        // R6 / R8: store window and blocked stores
        issue(3, 2, 3, 6'h2A, 0, "R6");
        chk(busy == 1'b1, "R6 busy after store", 64'(busy), 1);
        issue(3, 0, 1, 6'h11, 0, "R8");
        issue(1, 3, 0, 6'h05, 0, "R8");
        issue(4, 0, 1, 0, 0, "R8 blocked store left slot");
        issue(2, 3, 0, 0, 0, "R8 wiper write during busy");
        issue(4, 2, 3, 0, 0, "R6 stored slot");
        wait_idle();
        chk(busy == 1'b0, "R6 busy released", 64'(busy), 0);

        // R5: single-channel copies
        issue(5, 2, 3, 0, 0, "R5");
        issue(2, 2, 0, 0, 0, "R5 slot to wiper");
        issue(6, 1, 2, 0, 0, "R5");
        wait_idle();
        issue(4, 1, 2, 0, 0, "R5 wiper to slot");

        // R9: all-channel copies
        issue(8, 0, 0, 0, 0, "R9");
        wait_idle();
        for (int c = 0; c < NC; c++) issue(4, c, 0, 0, 0, "R9 save all into slot 0");
        issue(7, 0, 3, 0, 0, "R9");
        check_taps("R9 load all from slot 3");

        // R2 / R10: warm reset recall with slots kept
        issue(1, 0, 0, 6'h3A, 0, "R2");
        issue(1, 3, 0, 6'h01, 0, "R2");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NC; c++) m_w[c] = m_dr[c][0];
        check_taps("R2 recall from slot 0");
        issue(4, 2, 3, 0, 0, "R10 slot kept over warm reset");
        issue(4, 1, 2, 0, 0, "R10 slot kept over warm reset");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all reads returned", 64'(exp_q.size()), 0);
        finish_run();
    end

endmodule